// File: doc/BRIEF.md
# PLL Configuration Guard Registers

This block holds the settings of a clock synthesiser (a feedback multiplier M and an input pre-divider N, with the oscillator running at 2·M·Fin/N) and its two control bits, enable and connect. Software writes new settings into shadow registers. The settings reach the synthesiser only when a two-word unlock handshake completes on a dedicated feed address. A stray write therefore cannot retune or disconnect the clock.

The expected software sequence has four steps. First, load the multiplier and pre-divider, write enable only, and feed. Second, poll the status word until the lock flag is set. Third, write enable plus connect. Fourth, feed again. The connect output to the clock switch is gated by hardware. It is high only while the committed enable is set and the lock input is high. If lock is lost, the switch is released at once.

Top module: `pll_guard_regs`

Register map (word addresses on `bus_addr`):
- 0 CFG: M in bits [14:0], N in bits [23:16]. Reads return the shadow values.
- 1 CTRL: bit 0 enable, bit 1 connect. Reads return the shadow values.
- 2 FEED: write only, reads 0.
- 3 STATUS: committed M in [14:0], committed N in [23:16], committed enable in bit 24, committed connect in bit 25, and the lock input in bit 26.

## Requirements
- R1: After reset, the shadow and committed M, N, enable and connect are all zero. The outputs are low, and STATUS reads only the lock input in bit 26.
- R2: A write to CFG or CTRL updates only the shadow copy, which reads back at the same address. The committed outputs and STATUS do not change.
- R3: A FEED write of 0xAA followed by a FEED write of 0x55, with no other bus access between them, copies both shadow registers into the committed registers together. The change is visible in the cycle after the 0x55 write, and not during it.
- R4: If the FEED write after 0xAA carries any value other than 0x55 (a repeated 0xAA included), the handshake ends without a commit, and a later lone 0x55 commits nothing.
- R5: Any other bus access between the two feed words ends the handshake without a commit; a read or a write to another address counts as such an access. Idle cycles with `bus_valid` low do not end it.
- R6: A FEED write of 0x55 that does not directly follow an armed 0xAA commits nothing.
- R7: `pll_connect` is high only when the committed connect, the committed enable and `pll_lock` are all high. A committed connect without enable has no effect on `pll_connect`.
- R8: When `pll_lock` falls, `pll_connect` falls in the same cycle, while the committed connect bit is kept. When lock returns, `pll_connect` returns.
- R9: STATUS mirrors the committed (not the shadow) M, N, enable and connect, plus the live lock input, at the bit positions of the register map.
- R10: CTRL stores only bits 0 and 1; all other written bits read back as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pll_lock | input | 1 | Lock indication from the synthesiser |
| pll_mult | output | 15 | Committed multiplier M |
| pll_prediv | output | 8 | Committed pre-divider N |
| pll_enable | output | 1 | Committed enable |
| pll_connect | output | 1 | Gated connect to the clock switch |

## Verification
The assertions take the bus to be a single-cycle transaction: each cycle with `bus_valid` high is exactly one complete access. They also take `pll_lock` to be already synchronous to `clk`. The stimulus drives every access for exactly one clock, from the falling edge. It changes the lock input only at falling edges, so each feed word is seen once and the gating is observed without races.

// File: rtl/pll_guard_pkg.sv
package pll_guard_pkg;

  typedef enum logic [0:0] {FEED_IDLE = 1'b0, FEED_ARMED = 1'b1} feed_state_e;

  localparam logic [1:0] ADR_CFG    = 2'd0;
  localparam logic [1:0] ADR_CTRL   = 2'd1;
  localparam logic [1:0] ADR_FEED   = 2'd2;
  localparam logic [1:0] ADR_STATUS = 2'd3;

  localparam int N_LSB    = 16;
  localparam int EN_BIT   = 24;
  localparam int CONN_BIT = 25;
  localparam int LOCK_BIT = 26;

  // Next handshake state: any access leaves ARMED; only the first key arms.
  function automatic feed_state_e feed_next(feed_state_e cur, logic access,
                                            logic key1_wr);
    if (!access)               return cur;
    if (cur == FEED_ARMED)     return FEED_IDLE;
    return key1_wr ? FEED_ARMED : FEED_IDLE;
  endfunction

  // Oscillator frequency for given settings (zero pre-divider gives zero).
  function automatic longint unsigned cco_freq(longint unsigned fin,
                                               longint unsigned m,
                                               longint unsigned n);
    return (n == 0) ? 64'd0 : (2 * m * fin) / n;
  endfunction

endpackage

// File: rtl/pll_feed_fsm.sv
module pll_feed_fsm
  import pll_guard_pkg::*;
#(
  parameter int          DATA_W = 32,
  parameter logic [7:0]  KEY1   = 8'hAA,
  parameter logic [7:0]  KEY2   = 8'h55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              access,
  input  logic              feed_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              armed,
  output logic              commit
);

  localparam logic [DATA_W-1:0] K1 = DATA_W'(KEY1);
  localparam logic [DATA_W-1:0] K2 = DATA_W'(KEY2);

  feed_state_e state;
  logic key1_wr, key2_wr;

  assign key1_wr = feed_wr && (wdata == K1);
  assign key2_wr = feed_wr && (wdata == K2);
  assign armed   = (state == FEED_ARMED);
  assign commit  = armed && access && key2_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= FEED_IDLE;
    else        state <= feed_next(state, access, key1_wr);
  end

  // R4: first key from idle arms the handshake
  a_r4_key1_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && access && key1_wr) |=> armed);

  // R5: any access while armed ends the handshake
  a_r5_access_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && access) |=> !armed);

  // R5: idle cycles keep the armed state
  a_r5_idle_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !access) |=> armed);

  // R3: a commit is a single-cycle event
  a_r3_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

endmodule

// File: rtl/pll_cfg_bank.sv
module pll_cfg_bank #(
  parameter int M_W = 15,
  parameter int N_W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_wr,
  input  logic           ctrl_wr,
  input  logic [M_W-1:0] wr_m,
  input  logic [N_W-1:0] wr_n,
  input  logic           wr_en,
  input  logic           wr_conn,
  input  logic           commit,
  output logic [M_W-1:0] pend_m,
  output logic [N_W-1:0] pend_n,
  output logic           pend_en,
  output logic           pend_conn,
  output logic [M_W-1:0] act_m,
  output logic [N_W-1:0] act_n,
  output logic           act_en,
  output logic           act_conn
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_m <= '0;
      pend_n <= '0;
    end else if (cfg_wr) begin
      pend_m <= wr_m;
      pend_n <= wr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_en   <= 1'b0;
      pend_conn <= 1'b0;
    end else if (ctrl_wr) begin
      pend_en   <= wr_en;
      pend_conn <= wr_conn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_m    <= '0;
      act_n    <= '0;
      act_en   <= 1'b0;
      act_conn <= 1'b0;
    end else if (commit) begin
      act_m    <= pend_m;
      act_n    <= pend_n;
      act_en   <= pend_en;
      act_conn <= pend_conn;
    end
  end

  // R3: a commit copies every shadow field together
  a_r3_commit_copies: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (act_m == $past(pend_m) && act_n == $past(pend_n) &&
                act_en == $past(pend_en) && act_conn == $past(pend_conn)));

  // R2: without a commit the committed set does not move
  a_r2_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(act_m) && $stable(act_n) &&
                 $stable(act_en) && $stable(act_conn)));

endmodule

// File: rtl/pll_connect_gate.sv
module pll_connect_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic act_en,
  input  logic act_conn,
  input  logic lock,
  output logic eff_conn
);

  assign eff_conn = act_conn & act_en & lock;

  // R8: without lock the switch is never connected
  a_r8_no_lock_no_conn: assert property (@(posedge clk) disable iff (!rst_n)
    !lock |-> !eff_conn);

  // R7: no connection unless enabled
  a_r7_conn_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    eff_conn |-> act_en);

endmodule

// File: rtl/pll_guard_regs.sv
module pll_guard_regs
  import pll_guard_pkg::*;
#(
  parameter int         DATA_W = 32,
  parameter int         M_W    = 15,
  parameter int         N_W    = 8,
  parameter logic [7:0] KEY1   = 8'hAA,
  parameter logic [7:0] KEY2   = 8'h55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              pll_lock,
  output logic [M_W-1:0]    pll_mult,
  output logic [N_W-1:0]    pll_prediv,
  output logic              pll_enable,
  output logic              pll_connect
);

  logic wr, cfg_wr, ctrl_wr, feed_wr;
  logic armed, commit;
  logic [M_W-1:0] pend_m, act_m;
  logic [N_W-1:0] pend_n, act_n;
  logic pend_en, pend_conn, act_en, act_conn;

  assign wr      = bus_valid && bus_write;
  assign cfg_wr  = wr && (bus_addr == ADR_CFG);
  assign ctrl_wr = wr && (bus_addr == ADR_CTRL);
  assign feed_wr = wr && (bus_addr == ADR_FEED);

  pll_feed_fsm #(.DATA_W(DATA_W), .KEY1(KEY1), .KEY2(KEY2)) u_feed (
    .clk(clk), .rst_n(rst_n), .access(bus_valid), .feed_wr(feed_wr),
    .wdata(bus_wdata), .armed(armed), .commit(commit)
  );

  pll_cfg_bank #(.M_W(M_W), .N_W(N_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .ctrl_wr(ctrl_wr),
    .wr_m(bus_wdata[M_W-1:0]), .wr_n(bus_wdata[N_LSB +: N_W]),
    .wr_en(bus_wdata[0]), .wr_conn(bus_wdata[1]), .commit(commit),
    .pend_m(pend_m), .pend_n(pend_n), .pend_en(pend_en), .pend_conn(pend_conn),
    .act_m(act_m), .act_n(act_n), .act_en(act_en), .act_conn(act_conn)
  );

  pll_connect_gate u_gate (
    .clk(clk), .rst_n(rst_n), .act_en(act_en), .act_conn(act_conn),
    .lock(pll_lock), .eff_conn(pll_connect)
  );

  assign pll_mult   = act_m;
  assign pll_prediv = act_n;
  assign pll_enable = act_en;

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADR_CFG: begin
        bus_rdata[M_W-1:0]      = pend_m;
        bus_rdata[N_LSB +: N_W] = pend_n;
      end
      ADR_CTRL: begin
        bus_rdata[0] = pend_en;
        bus_rdata[1] = pend_conn;
      end
      ADR_FEED: bus_rdata = '0;
      ADR_STATUS: begin
        bus_rdata[M_W-1:0]      = act_m;
        bus_rdata[N_LSB +: N_W] = act_n;
        bus_rdata[EN_BIT]       = act_en;
        bus_rdata[CONN_BIT]     = act_conn;
        bus_rdata[LOCK_BIT]     = pll_lock;
      end
      default: bus_rdata = '0;
    endcase
  end

  // R9: status enable field follows the committed enable output
  a_r9_status_en: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADR_STATUS) |-> (bus_rdata[EN_BIT] == pll_enable));

  // R2: shadow writes alone never move the committed outputs
  a_r2_no_commit_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed) |=> ($stable(pll_mult) && $stable(pll_enable)));

endmodule

// File: tb/tb_pll_guard_regs.sv
module tb_pll_guard_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pll_lock = 1'b0;
  logic [14:0] pll_mult;
  logic [7:0]  pll_prediv;
  logic        pll_enable;
  logic        pll_connect;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pll_guard_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pll_lock(pll_lock), .pll_mult(pll_mult), .pll_prediv(pll_prediv),
    .pll_enable(pll_enable), .pll_connect(pll_connect)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] status_word(input logic [14:0] m,
      input logic [7:0] n, input logic en, input logic cn, input logic lk);
    return {5'd0, lk, cn, en, n, 1'b0, m};
  endfunction

  // one-cycle write; returns at the following falling edge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic feed();
    wr(2'd2, 32'hAA);
    wr(2'd2, 32'h55);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 mult", 32'(pll_mult), 0);
    check("R1 prediv", 32'(pll_prediv), 0);
    check("R1 enable/connect", {30'd0, pll_enable, pll_connect}, 0);
    rd(2'd3, d); check("R1 status", d, 0);
    rd(2'd0, d); check("R1 cfg shadow", d, 0);
  endtask

  task automatic t_shadow();
    logic [31:0] d;
    wr(2'd0, {8'd0, 8'd5, 1'b0, 15'd99});
    rd(2'd0, d); check("R2 cfg readback", d, {8'd0, 8'd5, 1'b0, 15'd99});
    wr(2'd1, 32'hFFFF_FFFD);
    rd(2'd1, d); check("R10 ctrl only two bits", d, 32'h1);
    check("R2 outputs unchanged", {pll_enable, 8'(pll_mult)}, 0);
    rd(2'd3, d); check("R2 status unchanged", d, 0);
  endtask

  task automatic t_good_feed();
    logic [31:0] d;
    wr(2'd2, 32'hAA);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 2'd2; bus_wdata = 32'h55;
    #1 check("R3 not during 0x55 cycle", {31'd0, pll_enable}, 0);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    check("R3 mult committed", 32'(pll_mult), 99);
    check("R3 prediv committed", 32'(pll_prediv), 5);
    check("R3 enable committed", {31'd0, pll_enable}, 1);
    rd(2'd3, d); check("R9 status mirrors", d, status_word(15'd99, 8'd5, 1'b1, 1'b0, 1'b0));
  endtask

  task automatic t_bad_feed();
    logic [31:0] d;
    wr(2'd0, {8'd0, 8'd7, 1'b0, 15'd200});
    wr(2'd2, 32'hAA); wr(2'd2, 32'hAA); wr(2'd2, 32'h55);
    check("R4 AA AA 55 no commit", 32'(pll_mult), 99);
    wr(2'd2, 32'hAA); wr(2'd2, 32'h56); wr(2'd2, 32'h55);
    check("R4 AA 56 no commit", 32'(pll_mult), 99);
    wr(2'd2, 32'h55);
    check("R6 lone 55 no commit", 32'(pll_mult), 99);
    rd(2'd3, d); check("R9 status keeps committed", d, status_word(15'd99, 8'd5, 1'b1, 1'b0, 1'b0));
  endtask

  task automatic t_interrupt();
    logic [31:0] d;
    wr(2'd2, 32'hAA); rd(2'd3, d); wr(2'd2, 32'h55);
    check("R5 read between feeds", 32'(pll_mult), 99);
    wr(2'd2, 32'hAA); wr(2'd1, 32'h1); wr(2'd2, 32'h55);
    check("R5 write between feeds", 32'(pll_mult), 99);
    wr(2'd2, 32'hAA);
    repeat (3) @(negedge clk);
    wr(2'd2, 32'h55);
    check("R5 idle gap still commits", 32'(pll_mult), 200);
    check("R5 prediv after gap", 32'(pll_prediv), 7);
  endtask

  task automatic t_connect();
    logic [31:0] d;
    wr(2'd1, 32'h3); feed();
    check("R7 connect without lock", {31'd0, pll_connect}, 0);
    rd(2'd3, d); check("R9 connect bit committed", d, status_word(15'd200, 8'd7, 1'b1, 1'b1, 1'b0));
    @(negedge clk); pll_lock = 1'b1;
    #1 check("R7 connect with lock", {31'd0, pll_connect}, 1);
    wr(2'd1, 32'h2); feed();
    check("R7 connect without enable", {30'd0, pll_enable, pll_connect}, 0);
  endtask

  task automatic t_lock_loss();
    logic [31:0] d;
    wr(2'd1, 32'h3); feed();
    check("R8 connected before loss", {31'd0, pll_connect}, 1);
    @(negedge clk); pll_lock = 1'b0;
    #1 check("R8 lock loss disconnects", {31'd0, pll_connect}, 0);
    rd(2'd3, d); check("R8 committed connect kept", d, status_word(15'd200, 8'd7, 1'b1, 1'b1, 1'b0));
    @(negedge clk); pll_lock = 1'b1;
    #1 check("R8 lock return reconnects", {31'd0, pll_connect}, 1);
    rd(2'd3, d); check("R9 lock bit", d, status_word(15'd200, 8'd7, 1'b1, 1'b1, 1'b1));
  endtask

  initial begin
    #2_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_shadow();
    t_good_feed();
    t_bad_feed();
    t_interrupt();
    t_connect();
    t_lock_loss();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule